// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Controller

This block collects 64 interrupt source lines into one request line for a processor. The sources are split into two banks of 32. Each bank has four word registers: latched rising edges (event), a mask (enable), a write-one-to-clear acknowledge, and a read-only view of the present input state (level). Every source line passes through a two-flop synchronizer before edge detection and level readback.

Software reaches the registers through a simple word-addressed port inside a 16-word (0x40-byte) window. The request output is high while any enabled source has a latched event. Software must work out which source to service from the event, level and enable registers. Level-style sources are pending when (event OR level) AND enable is set, and software computes that itself. Enabling a source whose line is already high latches nothing and raises no request.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every event and enable bit reads 0 and `irqOut` is low.
- R2: Register word address = bank base word + register offset. Bank 0 (sources 0–31) has its base at word 8 (byte 0x20). Bank 1 (sources 32–63) has its base at word 4 (byte 0x10). The offsets are: event +0, enable +1, ack +2, level +3. Source n is bit n mod 32 of bank n/32. Data bit k is register bit k, so byte 0 is on bits 7:0 (little-endian).
- R3: A rising edge on a source, seen after the two-flop synchronizer, sets its event bit. This happens whether or not the source is enabled.
- R4: Writing to ack clears each event bit whose data bit is 1 and leaves the others alone. If a new edge arrives in the same cycle as the ack write, the new edge wins and the event bit stays set.
- R5: The enable register reads back the last value written to it.
- R6: Setting an enable bit while that source's input is already high sets no event bit and raises no request.
- R7: The level register returns the synchronized input state.
- R8: `irqOut` is a register holding the OR over both banks of (event AND enable). It goes high or low on the clock edge after the condition changes.
- R9: These accesses have no effect:
  - writes to event or level;
  - writes to words outside the two banks.
- R10: These reads return 0:
  - reads of ack;
  - reads of words outside the two banks.
- R11: `regRdata` is updated on the clock edge that samples `regRd`, and keeps its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 64 | Asynchronous interrupt source lines |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 4 | Word address within the 0x40-byte window |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, registered |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The bench checks the bank placement. A design that swapped the banks or the register order would report source 0 in the wrong word. The bench also tests enabling a source whose line is already high. A design that treated the enable write as an edge would raise a request there. It also drives an ack in the same cycle as a fresh edge on the same bit, and a design that let the clear win would lose that interrupt. Cycle-exact checks on `irqOut` rise and fall catch an extra or missing pipeline stage. Checks on writes to event, level and unmapped words catch a design that lets software corrupt state through those words.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int BANK_IDX_W = 8;

  typedef enum logic [1:0] {
    REG_EVENT  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_ACK    = 2'd2,
    REG_LEVEL  = 2'd3
  } regKind_e;

  typedef struct packed {
    logic                  wrEnable;
    logic                  wrAck;
    logic                  rdStrobe;
    logic                  rdHit;
    regKind_e              kind;
    logic [BANK_IDX_W-1:0] bank;
  } ctrlStrobe_t;
endpackage

// File: rtl/bic_sync.sv
module bic_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/bic_decode.sv
module bic_decode
  import bic_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W = 4,
  parameter logic [NUM_BANKS*ADDR_W-1:0] BANK_BASE = 8'h48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       strobe
);
  logic                  hit;
  logic [BANK_IDX_W-1:0] bankSel;
  regKind_e              kind;

  always_comb begin
    hit     = 1'b0;
    bankSel = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (regAddr[ADDR_W-1:2] == BANK_BASE[b*ADDR_W+2 +: ADDR_W-2]) begin
        hit     = 1'b1;
        bankSel = BANK_IDX_W'(b);
      end
    end
    kind = regKind_e'(regAddr[1:0]);
  end

  always_comb begin
    strobe.wrEnable = regWr && hit && (kind == REG_ENABLE);
    strobe.wrAck    = regWr && hit && (kind == REG_ACK);
    strobe.rdStrobe = regRd;
    strobe.rdHit    = hit;
    strobe.kind     = kind;
    strobe.bank     = bankSel;
  end

  // R9: at most one kind of write strobe per cycle
  a_r9_one_write_kind: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrEnable, strobe.wrAck}));

  // R9: a miss on both banks never produces a write strobe
  a_r9_miss_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdHit |-> (!strobe.wrEnable && !strobe.wrAck));
endmodule

// File: rtl/bic_bank_path.sv
module bic_bank_path
  import bic_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_BANKS*BANK_W-1:0] levelIn,
  input  ctrlStrobe_t                 strobe,
  input  logic [BANK_W-1:0]           wdata,
  output logic [BANK_W-1:0]           rdata,
  output logic                        irqOut
);
  localparam int N = NUM_BANKS * BANK_W;

  logic [N-1:0] prevLevel, eventQ, enableQ, riseVec;
  logic [N-1:0] ackAll, enMaskAll, enDataAll;
  logic [BANK_W-1:0] selWord;

  assign riseVec   = levelIn & ~prevLevel;
  assign enDataAll = {NUM_BANKS{wdata}};

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic bankHit;
    assign bankHit = (strobe.bank == BANK_IDX_W'(gb));
    assign ackAll[gb*BANK_W +: BANK_W]    = (strobe.wrAck && bankHit) ? wdata : '0;
    assign enMaskAll[gb*BANK_W +: BANK_W] = {BANK_W{strobe.wrEnable && bankHit}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLevel <= '0;
      eventQ    <= '0;
      enableQ   <= '0;
      irqOut    <= 1'b0;
    end else begin
      prevLevel <= levelIn;
      eventQ    <= (eventQ & ~ackAll) | riseVec;
      enableQ   <= (enableQ & ~enMaskAll) | (enDataAll & enMaskAll);
      irqOut    <= |(eventQ & enableQ);
    end
  end

  always_comb begin
    selWord = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobe.bank == BANK_IDX_W'(b)) begin
        case (strobe.kind)
          REG_EVENT:  selWord = eventQ[b*BANK_W +: BANK_W];
          REG_ENABLE: selWord = enableQ[b*BANK_W +: BANK_W];
          REG_LEVEL:  selWord = levelIn[b*BANK_W +: BANK_W];
          default:    selWord = '0;
        endcase
      end
    end
    if (!strobe.rdHit) selWord = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdata <= '0;
    else if (strobe.rdStrobe) rdata <= selWord;
  end

  // R3 / R6: an event bit appears only after a synchronized rising edge
  a_r3_set_only_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((eventQ & ~$past(eventQ) & ~$past(riseVec)) == '0));

  // R4: acknowledged bits without a coincident edge are cleared
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrAck |=> ((eventQ & $past(ackAll & ~riseVec)) == '0));

  // R5: enable holds the written data on the written bank
  a_r5_enable_readback: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEnable |=> (((enableQ ^ $past(enDataAll)) & $past(enMaskAll)) == '0));

  // R8: a request needs some enabled source in the prior cycle
  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(|enableQ));
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import bic_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W = 32,
  parameter int ADDR_W = 4,
  parameter logic [NUM_BANKS*ADDR_W-1:0] BANK_BASE = 8'h48
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_BANKS*BANK_W-1:0] srcIn,
  input  logic                        regWr,
  input  logic                        regRd,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [BANK_W-1:0]           regWdata,
  output logic [BANK_W-1:0]           regRdata,
  output logic                        irqOut
);
  localparam int N = NUM_BANKS * BANK_W;

  logic [N-1:0] levelSync;
  ctrlStrobe_t  strobe;

  bic_sync #(.WIDTH(N)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(srcIn), .syncOut(levelSync)
  );

  bic_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .strobe(strobe)
  );

  bic_bank_path #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_path (
    .clk(clk), .rstN(rstN), .levelIn(levelSync), .strobe(strobe),
    .wdata(regWdata), .rdata(regRdata), .irqOut(irqOut)
  );
endmodule

// File: tb/banked_irq_ctrl_test.sv
module banked_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] srcIn = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [63:0] expEv = '0, expEn = '0;

  always #2 clk = ~clk;

  banked_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  function automatic logic [3:0] baseWord(input int bank);
    return (bank == 0) ? 4'd8 : 4'd4;
  endfunction

  function automatic logic expIrq();
    return |(expEv & expEn);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
  endtask

  task automatic chkReg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, {32'b0, d}, {32'b0, exp});
  endtask

  task automatic setSrc(input logic [63:0] v);
    expEv = expEv | (v & ~srcIn);
    srcIn = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic chkAll(input string req);
    for (int b = 0; b < 2; b++) begin
      chkReg(req, baseWord(b) + 4'd0, expEv[b*32 +: 32]);
      chkReg(req, baseWord(b) + 4'd1, expEn[b*32 +: 32]);
      chkReg(req, baseWord(b) + 4'd3, srcIn[b*32 +: 32]);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {63'b0, irqOut}, 64'd0);
    chkAll("R1 reset regs");

    // R2 / R3: edges latch while disabled, bank placement
    setSrc(64'h0000_0001_0000_0001);
    chkReg("R2 bank0 event at word8", 4'd8, 32'h1);
    chkReg("R2 bank1 event at word4", 4'd4, 32'h1);
    setSrc(64'h0000_0021_0000_0001);
    chkReg("R3 source 37 bit5 bank1", 4'd4, 32'h21);
    chkReg("R7 level bank0", 4'd11, 32'h1);
    check("R3 no irq while disabled", {63'b0, irqOut}, 64'd0);

    // R7: level follows input, events persist
    setSrc(64'h0);
    chkReg("R7 level low", 4'd7, 32'h0);
    chkReg("R3 event persists", 4'd4, 32'h21);

    // R4: zero ack no effect, one ack clears
    wr(4'd6, 32'h0);
    chkReg("R4 zero ack no effect", 4'd4, 32'h21);
    wr(4'd6, 32'h20); expEv[37] = 1'b0;
    chkReg("R4 ack clears bit", 4'd4, 32'h1);

    // R9 / R10: ignored writes and zero reads
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd11, 32'hFFFF_FFFF);
    wr(4'd0, 32'hFFFF_FFFF);
    chkReg("R9 event write ignored", 4'd8, 32'h1);
    chkReg("R9 level write ignored", 4'd11, 32'h0);
    chkReg("R10 ack reads zero", 4'd10, 32'h0);
    chkReg("R10 unmapped word0 zero", 4'd0, 32'h0);
    chkReg("R10 unmapped word12 zero", 4'd12, 32'h0);
    check("R9 irq unaffected", {63'b0, irqOut}, 64'd0);

    // R8: cycle-exact irq rise and fall
    wr(4'd8 + 4'd2, 32'h1); wr(4'd6, 32'h1); expEv[0] = 1'b0; expEv[32] = 1'b0;
    setSrc(64'h8);
    wr(4'd9, 32'h8); expEn[3] = 1'b1;
    check("R8 irq not yet", {63'b0, irqOut}, 64'd0);
    @(negedge clk);
    check("R8 irq one cycle later", {63'b0, irqOut}, 64'd1);
    chkReg("R5 enable readback", 4'd9, 32'h8);
    wr(4'd10, 32'h8); expEv[3] = 1'b0;
    check("R8 irq holds one cycle", {63'b0, irqOut}, 64'd1);
    @(negedge clk);
    check("R8 irq falls", {63'b0, irqOut}, 64'd0);

    // R6: enable while input already high
    setSrc(64'h8 | (64'h1 << 40));
    wr(4'd6, 32'h100); expEv[40] = 1'b0;
    wr(4'd5, 32'h100); expEn[40] = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 no irq on enable-while-high", {63'b0, irqOut}, 64'd0);
    chkReg("R6 no event on enable-while-high", 4'd4, 32'h0);
    setSrc(64'h0);

    // R4: ack coinciding with a fresh edge keeps the event
    srcIn = 64'h2;
    @(negedge clk); @(negedge clk);
    wr(4'd10, 32'h2);
    expEv[1] = 1'b1;
    repeat (3) @(negedge clk);
    chkReg("R4 edge beats ack", 4'd8, 32'h2);

    // R11: read data holds without a read strobe
    rd(4'd8, d);
    wr(4'd10, 32'h2); expEv[1] = 1'b0;
    check("R11 rdata held", {32'b0, regRdata}, {32'b0, 32'h2});
    chkReg("R11 new read", 4'd8, 32'h0);

    // random phase
    for (int it = 0; it < 40; it++) begin
      logic [63:0] nv;
      int op;
      nv = {$urandom, $urandom} & {$urandom, $urandom};
      setSrc(nv);
      op = $urandom_range(0, 2);
      if (op == 0) begin
        int b; logic [31:0] m;
        b = $urandom_range(0, 1); m = $urandom;
        wr(baseWord(b) + 4'd1, m); expEn[b*32 +: 32] = m;
      end else if (op == 1) begin
        int b; logic [31:0] m;
        b = $urandom_range(0, 1); m = $urandom;
        wr(baseWord(b) + 4'd2, m); expEv[b*32 +: 32] &= ~m;
      end
      repeat (2) @(negedge clk);
      check("R8 random irq", {63'b0, irqOut}, {63'b0, expIrq()});
      if (it % 5 == 0) chkAll("R3 R4 R5 R7 random regs");
    end

    finishRun();
  end
endmodule